// File: doc/BRIEF.md
# Debug-Port Memory Bridge

This block is a test access port that lets an external debugger reach system memory. Besides the usual identification and bypass instructions, it offers three private instructions. One loads a bus address. One reads memory word by word. One swaps a word: it writes the new word and returns the old one. Each completed data scan under a memory instruction starts one transaction on a classic single-beat Wishbone master port. After every access the address advances by one word, so a run of scans walks through consecutive locations.

The debug side (`tck`, `tms`, `tdi`, `tdo`) runs about ten times slower than the system clock that drives the bus side. The bus side reads the word at the current address ahead of time, after every address load and every access. That word is therefore ready when the next scan captures it. Requests and completions cross between the two clocks as toggles, each through a two-flop synchronizer. Reset is synchronous and active low in both clock domains. `rst_n` must be held low across a few edges of each clock. The port can also be reset at any time by holding `tms` high for five edges of `tck`.

Top module: `jwb_bridge`

## Requirements
- R1: A port reset, from `rst_n` or from five `tck` edges with `tms` high, selects the identification instruction (code 1). A 32-bit data scan under that instruction shifts out the `IDCODE` parameter, least significant bit first.
- R2: The instruction register is 4 bits wide and captures 4'b0001 at the start of an instruction scan. Any code other than 1, 5, 6 and 7 selects a 1-bit bypass stage that captures 0. Each bit shifted out of the bypass stage is the bit shifted in one edge earlier.
- R3: Under code 5, a scan of `ADDR_W` bits loads the shifted-in value as the current word address when the scan completes. The same scan shifts out the current address as it stood before the load.
- R4: Under code 7, each 64-bit data scan shifts out the word stored at the current address. When the scan completes, the shifted-in word is written to that address.
- R5: Under code 6, each 64-bit data scan shifts out the word at the current address. Memory is not written, and the shifted-in bits have no effect.
- R6: After every read or read-write access, the current address goes up by one word.
- R7: On the bus, `wb_cyc_o` equals `wb_stb_o`, and `wb_sel_o` is all ones. `wb_we_o` is high only for the write half of a read-write access. Address, write enable and write data stay stable until `wb_ack_i`.
- R8: After every address load, and after every access, the bridge issues one bus read at the new current address. After reset it issues one read at address 0.
- R9: If a memory data scan completes while the previous bus work has not yet been acknowledged back to the debug side, that scan is dropped. It starts no transaction and does not change the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus side |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clock domains |
| tck | input | 1 | Debug test clock |
| tms | input | 1 | Debug mode select, sampled on rising `tck` |
| tdi | input | 1 | Debug serial data in, sampled on rising `tck` |
| tdo | output | 1 | Debug serial data out, changes on falling `tck` |
| wb_adr_o | output | ADDR_W | Bus word address |
| wb_dat_o | output | DATA_W | Bus write data |
| wb_sel_o | output | DATA_W/8 | Byte selects, all ones |
| wb_we_o | output | 1 | Bus write enable |
| wb_cyc_o | output | 1 | Bus cycle valid |
| wb_stb_o | output | 1 | Bus strobe |
| wb_dat_i | input | DATA_W | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |

## Verification
Serial results appear on `tdo` at the falling `tck` edge that follows the capture or shift edge. The bench drives `tms` and `tdi` while `tck` is low and samples `tdo` half a `tck` period later, just before the next rising edge. The bus work set off by the Update-DR edge needs about three system clocks to synchronize, then two or four more for the write and the prefetch, and then two `tck` edges to return the completion. The bench therefore idles four `tck` periods, forty system clocks, after every data scan before it starts the next one. To test the dropped-scan rule, the bench memory withholds `wb_ack_i`. This keeps the first request pending across a whole second scan, and a later address capture then shows which of the two loads took effect.

// File: rtl/jwb_pkg.sv
// Shared types for the debug-port memory bridge.
// Assumes: instruction register fixed at 4 bits.
package jwb_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE, TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR,
        TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_READ = 2'd1,
        OP_SWAP = 2'd2
    } mem_op_e;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] IR_IDENT  = 4'd1;
    localparam logic [IR_W-1:0] IR_ALOAD  = 4'd5;
    localparam logic [IR_W-1:0] IR_MREAD  = 4'd6;
    localparam logic [IR_W-1:0] IR_MSWAP  = 4'd7;
    localparam logic [IR_W-1:0] IR_CAPVAL = 4'b0001;

endpackage

// File: rtl/jwb_tap_fsm.sv
// Test access port state machine, advanced on rising tck by tms.
// Assumes: rst_n held low across at least one rising tck edge.
module jwb_tap_fsm
    import jwb_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next-state decode of the sixteen-state port controller.
    always_comb begin
        unique case (state)
            TS_RESET:  nxt = tms ? TS_RESET  : TS_IDLE;
            TS_IDLE:   nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: nxt = tms ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_SH_DR:  nxt = tms ? TS_EX1_DR : TS_SH_DR;
            TS_EX1_DR: nxt = tms ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: nxt = tms ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: nxt = tms ? TS_UPD_DR : TS_SH_DR;
            TS_UPD_DR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: nxt = tms ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_SH_IR:  nxt = tms ? TS_EX1_IR : TS_SH_IR;
            TS_EX1_IR: nxt = tms ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: nxt = tms ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: nxt = tms ? TS_UPD_IR : TS_SH_IR;
            TS_UPD_IR: nxt = tms ? TS_SEL_DR : TS_IDLE;
            default:   nxt = TS_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= TS_RESET;
        else        state <= nxt;
    end

    // R1: the reset state is held for as long as tms stays high.
    p_reset_hold_r1: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET && tms) |=> state == TS_RESET);

endmodule

// File: rtl/jwb_tck_regs.sv
// Debug-clock side: instruction register, shared data shift register,
// serial output, and the request toggle towards the bus side.
// Assumes: cur_addr_i and rdata_i are stable whenever no request is
// pending (guaranteed by the toggle handshake).
module jwb_tck_regs
    import jwb_pkg::*;
#(
    parameter int          ADDR_W = 29,
    parameter int          DATA_W = 64,
    parameter logic [31:0] IDCODE = 32'h1A5E_0F01
) (
    input  logic              tck,
    input  logic              rst_n,
    input  logic              tdi,
    input  tap_state_e        state,
    output logic              tdo,
    output logic              req_tgl,
    output mem_op_e           req_op,
    output logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] req_wdata,
    input  logic              done_tgl,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [DATA_W-1:0] rdata_i
);

    localparam int SR_A = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int SR_W = (SR_A > 32) ? SR_A : 32;

    logic [IR_W-1:0] ir, ir_sr;
    logic [SR_W-1:0] dr_sr, sh_nxt, cap_val;
    logic            done_s1, done_s2;
    logic            busy, is_mem;
    int              dr_len;

    assign busy   = req_tgl ^ done_s2;
    assign is_mem = (ir == IR_ALOAD) || (ir == IR_MREAD) || (ir == IR_MSWAP);

    // Length and capture value of the selected data register.
    always_comb begin
        unique case (ir)
            IR_IDENT: begin dr_len = 32;     cap_val = SR_W'(IDCODE);     end
            IR_ALOAD: begin dr_len = ADDR_W; cap_val = SR_W'(cur_addr_i); end
            IR_MREAD,
            IR_MSWAP: begin dr_len = DATA_W; cap_val = SR_W'(rdata_i);    end
            default:  begin dr_len = 1;      cap_val = '0;                end
        endcase
    end

    // One shift step: tdi enters at the top bit of the selected length.
    always_comb begin
        for (int i = 0; i < SR_W; i++) begin
            if (i == dr_len - 1)     sh_nxt[i] = tdi;
            else if (i < dr_len - 1) sh_nxt[i] = dr_sr[i+1];
            else                     sh_nxt[i] = 1'b0;
        end
    end

    // Register actions on rising tck, keyed by the current port state.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            ir        <= IR_IDENT;
            ir_sr     <= '0;
            dr_sr     <= '0;
            req_tgl   <= 1'b0;
            req_op    <= OP_LOAD;
            req_addr  <= '0;
            req_wdata <= '0;
            done_s1   <= 1'b0;
            done_s2   <= 1'b0;
        end else begin
            done_s1 <= done_tgl;
            done_s2 <= done_s1;
            unique case (state)
                TS_RESET:  ir    <= IR_IDENT;
                TS_CAP_IR: ir_sr <= IR_CAPVAL;
                TS_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                TS_UPD_IR: ir    <= ir_sr;
                TS_CAP_DR: dr_sr <= cap_val;
                TS_SH_DR:  dr_sr <= sh_nxt;
                TS_UPD_DR: begin
                    if (is_mem && !busy) begin
                        req_tgl   <= ~req_tgl;
                        req_addr  <= dr_sr[ADDR_W-1:0];
                        req_wdata <= dr_sr[DATA_W-1:0];
                        req_op    <= (ir == IR_ALOAD) ? OP_LOAD :
                                     (ir == IR_MREAD) ? OP_READ : OP_SWAP;
                    end
                end
                default: ;
            endcase
        end
    end

    // Serial output changes on falling tck from the active shift register.
    always_ff @(negedge tck) begin
        if (!rst_n)                 tdo <= 1'b0;
        else if (state == TS_SH_DR) tdo <= dr_sr[0];
        else if (state == TS_SH_IR) tdo <= ir_sr[0];
        else                        tdo <= 1'b0;
    end

    // R1: leaving the reset state always leaves the identification code.
    p_ir_ident_r1: assert property (@(posedge tck) disable iff (!rst_n)
        state == TS_RESET |=> ir == IR_IDENT);

    // R9: a completed scan while busy does not issue a request.
    p_no_commit_busy_r9: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_UPD_DR && busy) |=> $stable(req_tgl));

    // R9: request payload is frozen while the bus side owns it.
    p_req_frozen_r9: assert property (@(posedge tck) disable iff (!rst_n)
        busy |=> ($stable(req_addr) && $stable(req_wdata) && $stable(req_op)));

endmodule

// File: rtl/jwb_bus_engine.sv
// System-clock side: synchronizes request toggles, runs single-beat
// bus cycles, keeps the current address and the prefetched word.
// Assumes: req_op/req_addr/req_wdata are stable from a request toggle
// until the matching done toggle.
module jwb_bus_engine
    import jwb_pkg::*;
#(
    parameter int ADDR_W = 29,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_tgl,
    input  mem_op_e             req_op,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                done_tgl,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [DATA_W-1:0]   rdata,
    output logic [ADDR_W-1:0]   wb_adr_o,
    output logic [DATA_W-1:0]   wb_dat_o,
    output logic [DATA_W/8-1:0] wb_sel_o,
    output logic                wb_we_o,
    output logic                wb_cyc_o,
    output logic                wb_stb_o,
    input  logic [DATA_W-1:0]   wb_dat_i,
    input  logic                wb_ack_i
);

    typedef enum logic [1:0] {BE_IDLE, BE_WR, BE_RD} be_state_e;

    be_state_e st;
    logic      req_s1, req_s2, req_s3, req_pulse;
    logic      pend;

    assign req_pulse = req_s2 ^ req_s3;

    // Bus outputs follow the engine state directly.
    assign wb_cyc_o = (st != BE_IDLE);
    assign wb_stb_o = wb_cyc_o;
    assign wb_we_o  = (st == BE_WR);
    assign wb_adr_o = cur_addr;
    assign wb_dat_o = req_wdata;
    assign wb_sel_o = '1;

    // Toggle synchronizer and edge detect for incoming requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_s1 <= 1'b0;
            req_s2 <= 1'b0;
            req_s3 <= 1'b0;
        end else begin
            req_s1 <= req_tgl;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
        end
    end

    // Engine: address update, optional write, then prefetch read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= BE_RD;
            pend     <= 1'b0;
            cur_addr <= '0;
            rdata    <= '0;
            done_tgl <= 1'b0;
        end else begin
            unique case (st)
                BE_IDLE: begin
                    if (req_pulse) begin
                        pend <= 1'b1;
                        unique case (req_op)
                            OP_LOAD: begin cur_addr <= req_addr;     st <= BE_RD; end
                            OP_READ: begin cur_addr <= cur_addr + 1'b1; st <= BE_RD; end
                            default: st <= BE_WR;
                        endcase
                    end
                end
                BE_WR: begin
                    if (wb_ack_i) begin
                        cur_addr <= cur_addr + 1'b1;
                        st       <= BE_RD;
                    end
                end
                default: begin
                    if (wb_ack_i) begin
                        rdata <= wb_dat_i;
                        st    <= BE_IDLE;
                        if (pend) begin
                            done_tgl <= ~done_tgl;
                            pend     <= 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    // R7: a cycle keeps address, direction and data until acknowledged.
    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && !wb_ack_i) |=>
            (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_we_o) && $stable(wb_dat_o)));

    // R6: an acknowledged write advances the address by one word.
    p_inc_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_we_o && wb_ack_i) |=> wb_adr_o == $past(wb_adr_o) + 1'b1);

    // R8: an acknowledged write is followed at once by a prefetch read.
    p_prefetch_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_cyc_o && wb_we_o && wb_ack_i) |=> (wb_cyc_o && !wb_we_o));

    // R9: a new request only ever arrives while the engine is idle.
    p_req_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_pulse |-> st == BE_IDLE);

endmodule

// File: rtl/jwb_bridge.sv
// Top level: debug port with memory-access instructions driving a
// single-beat bus master. Assumes tck is much slower than clk.
module jwb_bridge
    import jwb_pkg::*;
#(
    parameter int          ADDR_W = 29,
    parameter int          DATA_W = 64,
    parameter logic [31:0] IDCODE = 32'h1A5E_0F01
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tck,
    input  logic                tms,
    input  logic                tdi,
    output logic                tdo,
    output logic [ADDR_W-1:0]   wb_adr_o,
    output logic [DATA_W-1:0]   wb_dat_o,
    output logic [DATA_W/8-1:0] wb_sel_o,
    output logic                wb_we_o,
    output logic                wb_cyc_o,
    output logic                wb_stb_o,
    input  logic [DATA_W-1:0]   wb_dat_i,
    input  logic                wb_ack_i
);

    tap_state_e        tstate;
    logic              req_tgl, done_tgl;
    mem_op_e           req_op;
    logic [ADDR_W-1:0] req_addr, cur_addr;
    logic [DATA_W-1:0] req_wdata, rdata;

    jwb_tap_fsm u_fsm (
        .tck   (tck),
        .rst_n (rst_n),
        .tms   (tms),
        .state (tstate)
    );

    jwb_tck_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDCODE(IDCODE)) u_regs (
        .tck        (tck),
        .rst_n      (rst_n),
        .tdi        (tdi),
        .state      (tstate),
        .tdo        (tdo),
        .req_tgl    (req_tgl),
        .req_op     (req_op),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .done_tgl   (done_tgl),
        .cur_addr_i (cur_addr),
        .rdata_i    (rdata)
    );

    jwb_bus_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_tgl   (req_tgl),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .done_tgl  (done_tgl),
        .cur_addr  (cur_addr),
        .rdata     (rdata),
        .wb_adr_o  (wb_adr_o),
        .wb_dat_o  (wb_dat_o),
        .wb_sel_o  (wb_sel_o),
        .wb_we_o   (wb_we_o),
        .wb_cyc_o  (wb_cyc_o),
        .wb_stb_o  (wb_stb_o),
        .wb_dat_i  (wb_dat_i),
        .wb_ack_i  (wb_ack_i)
    );

endmodule

// File: tb/jwb_bridge_tb.sv
// Bench: drives the debug port serially against a 16-word behavioural memory.
module jwb_bridge_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          TCK_HALF   = 5 * CLK_PERIOD;
    localparam int          AW         = 29;
    localparam int          DW         = 64;
    localparam logic [31:0] ID         = 32'h1A5E_0F01;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          tck = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic          tdo;
    logic [AW-1:0] wb_adr;
    logic [DW-1:0] wb_dwr, wb_drd;
    logic [DW/8-1:0] wb_sel;
    logic          wb_we, wb_cyc, wb_stb, wb_ack;

    int tests = 0, fails = 0;
    int bus_viol = 0, wr_count = 0;
    logic [AW-1:0] last_rd_adr;
    logic          stall = 1'b0;
    logic [DW-1:0] mem [16];
    logic          prev_wait;
    logic [AW-1:0] prev_adr;

    jwb_bridge #(.ADDR_W(AW), .DATA_W(DW), .IDCODE(ID)) dut_i (
        .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .wb_adr_o(wb_adr), .wb_dat_o(wb_dwr), .wb_sel_o(wb_sel), .wb_we_o(wb_we),
        .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb), .wb_dat_i(wb_drd), .wb_ack_i(wb_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] init_w(int i);
        return 64'hA5A5_0000_0000_0000 ^ (64'(i) * 64'h0101_0101_0101_0101);
    endfunction
    function automatic logic [DW-1:0] pat1(int i);
        return 64'(i) * 64'h1111_1111_1111_1111 + 64'h55;
    endfunction
    function automatic logic [DW-1:0] pat2(int i);
        return {32'(i) ^ 32'hDEAD_0000, ~32'(i)};
    endfunction

    assign wb_drd = mem[wb_adr[3:0]];

    // Memory model: one wait state, ack withheld while stall is set.
    always @(posedge clk) begin
        if (!rst_n) begin
            wb_ack <= 1'b0;
            for (int i = 0; i < 16; i++) mem[i] <= init_w(i);
        end else begin
            wb_ack <= wb_cyc && wb_stb && !wb_ack && !stall;
            if (wb_cyc && wb_ack && wb_we) begin
                mem[wb_adr[3:0]] <= wb_dwr;
                wr_count <= wr_count + 1;
            end
            if (wb_cyc && wb_ack && !wb_we) last_rd_adr <= wb_adr;
        end
    end

    // Bus protocol monitor for R7.
    always @(posedge clk) begin
        if (!rst_n) begin
            prev_wait <= 1'b0;
            prev_adr  <= '0;
        end else begin
            if (wb_cyc != wb_stb) bus_viol <= bus_viol + 1;
            if (wb_cyc && wb_sel != '1) bus_viol <= bus_viol + 1;
            if (prev_wait && (!wb_cyc || wb_adr != prev_adr)) bus_viol <= bus_viol + 1;
            prev_wait <= wb_cyc && !wb_ack;
            prev_adr  <= wb_adr;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #(TCK_HALF);
        o = tdo;
        tck = 1'b1;
        #(TCK_HALF);
        tck = 1'b0;
    endtask

    task automatic idle(input int n);
        logic o;
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, o);
    endtask

    task automatic scan_ir(input logic [3:0] code, output logic [3:0] cap);
        logic o;
        tick(1, 0, o); tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], o);
            cap[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
        idle(2);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        tick(1, 0, o); tick(0, 0, o); tick(0, 0, o);
        for (int i = 0; i < len; i++) begin
            tick(i == len - 1, din[i], o);
            dout[i] = o;
        end
        tick(1, 0, o); tick(0, 0, o);
        idle(4);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        tests++; fails++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0]  irc;
        logic [63:0] q;
        logic        o;
        int          wc;
        // Reset both domains.
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0, o);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, o);
        idle(2);
        chk(wb_cyc == 1'b0, "R8 boot prefetch done", 64'(wb_cyc), 64'd0);
        chk(last_rd_adr == '0, "R8 boot prefetch address", 64'(last_rd_adr), 64'd0);

        // R1: identification after reset.
        scan_dr(32, 64'h0, q);
        chk(q[31:0] == ID, "R1 idcode after rst_n", q, 64'(ID));

        // R2: instruction capture and bypass sweep over all unused codes.
        for (int c = 0; c < 16; c++) begin
            if (c == 1 || (c >= 5 && c <= 7)) continue;
            scan_ir(4'(c), irc);
            chk(irc == 4'b0001, "R2 ir capture", 64'(irc), 64'd1);
            scan_dr(8, 64'(8'hB4 ^ 8'(c)), q);
            chk(q[7:0] == {7'(8'hB4 ^ 8'(c)), 1'b0}, "R2 bypass delay",
                q, 64'({7'(8'hB4 ^ 8'(c)), 1'b0}));
        end

        // R3/R8: load address 2.
        scan_ir(4'd5, irc);
        scan_dr(AW, 64'd2, q);
        chk(q[AW-1:0] == '0, "R3 address capture before load", q, 64'd0);
        chk(last_rd_adr == AW'(2), "R8 prefetch after load", 64'(last_rd_adr), 64'd2);

        // R4/R6: swap six words, each returns the old contents.
        scan_ir(4'd7, irc);
        for (int k = 0; k < 6; k++) begin
            scan_dr(DW, pat1(2 + k), q);
            chk(q == init_w(2 + k), "R4 swap returns old word", q, init_w(2 + k));
            chk(mem[2 + k] == pat1(2 + k), "R4 swap writes new word", mem[2 + k], pat1(2 + k));
        end

        // R3/R6: reload shows address advanced by six.
        scan_ir(4'd5, irc);
        scan_dr(AW, 64'd2, q);
        chk(q[AW-1:0] == AW'(8), "R6 address after six swaps", q, 64'd8);

        // R5: read six words, garbage input, no writes.
        wc = wr_count;
        scan_ir(4'd6, irc);
        for (int k = 0; k < 6; k++) begin
            scan_dr(DW, ~pat1(k), q);
            chk(q == pat1(2 + k), "R5 read returns stored word", q, pat1(2 + k));
        end
        chk(wr_count == wc, "R5 read issues no writes", 64'(wr_count), 64'(wc));
        for (int k = 0; k < 6; k++)
            chk(mem[2 + k] == pat1(2 + k), "R5 memory unchanged", mem[2 + k], pat1(2 + k));

        // R6: reads advance the address too.
        scan_ir(4'd5, irc);
        scan_dr(AW, 64'd2, q);
        chk(q[AW-1:0] == AW'(8), "R6 address after six reads", q, 64'd8);

        // R4: second swap pass returns the first pattern.
        scan_ir(4'd7, irc);
        for (int k = 0; k < 6; k++) begin
            scan_dr(DW, pat2(2 + k), q);
            chk(q == pat1(2 + k), "R4 second swap old word", q, pat1(2 + k));
        end

        // R6: walk across the model's wrap from 14 to 1.
        scan_ir(4'd5, irc);
        scan_dr(AW, 64'd14, q);
        chk(last_rd_adr == AW'(14), "R8 prefetch at 14", 64'(last_rd_adr), 64'd14);
        scan_ir(4'd6, irc);
        for (int k = 0; k < 4; k++) begin
            scan_dr(DW, 64'h0, q);
            chk(q == init_w((14 + k) % 16), "R6 consecutive read", q, init_w((14 + k) % 16));
        end

        // R9: hold ack, second load must be dropped.
        scan_ir(4'd5, irc);
        stall = 1'b1;
        scan_dr(AW, 64'd10, q);
        scan_dr(AW, 64'd3, q);
        stall = 1'b0;
        idle(4);
        scan_dr(AW, 64'd0, q);
        chk(q[AW-1:0] == AW'(10), "R9 load while busy dropped", q, 64'd10);

        // R7: protocol monitor over the whole run.
        chk(bus_viol == 0, "R7 bus protocol", 64'(bus_viol), 64'd0);

        // R1: reset from tms after a memory instruction.
        scan_ir(4'd6, irc);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o);
        tick(1'b0, 1'b0, o);
        scan_dr(32, 64'h0, q);
        chk(q[31:0] == ID, "R1 idcode after tms reset", q, 64'(ID));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule